// File: doc/BRIEF.md
# Buck-Boost Switching Phase Sequencer

This block is the digital core of a hysteretic, current-controlled, non-inverting buck-boost stage. Each clock cycle it reads digital comparator flags on the inductor current (over the first peak limit, over the sum of both peak limits, at or under the valley limit, under zero) and a VIN-above-VOUT flag. It then picks one of four switching phases and drives the four power switch gates. The phases are two charging phases, one discharge phase and one freewheel phase. Every phase turns on exactly two switches. Every change between phases passes through a short interval with all switches off.

Two configuration inputs select the behaviour. One picks between full buck-boost operation and a buck-only mode. The other disables the zero-current comparator, which decides whether continuous conduction inserts a short timed freewheel. A soft-start input forces discontinuous operation, ignores the valley limit and switches the peak comparisons over to a separate pair of soft-start limit flags. The charge timeout, the freewheel length and the dead time are counted in clock cycles and set as parameters. With a 100 MHz clock the defaults give 500 ns, 30 ns and 10 ns.

Top module: `bb_phase_seq`

## Requirements
- R1: After reset, and on the first clock edge that samples `enable` low, the phase code is 0 and all four gates are off. While `enable` stays low the block remains there, whatever its other inputs do.
- R2: Phase codes are 1 to 4. Code 1 turns on input-high and output-high. Code 2 turns on input-high and output-low. Code 3 turns on input-low and output-high. Code 4 turns on input-low and output-low. Code 0 means idle or dead time and has all gates off. Exactly two gates are on whenever the code is non-zero.
- R3: Every change from one phase to another passes through DEAD_CYC cycles of code 0 with all gates off.
- R4: In buck-boost mode (`buck_only` = 0), a charge request starts charging in phase 2. Phase 2 is left for phase 1 when the peak-limit-1 flag is sampled high.
- R5: In phase 1 with `vin_gt_vout` = 1, the sum-limit flag ends the phase (next phase 3). The peak-limit-1 flag alone does not end it.
- R6: In phase 1 in buck-boost mode with `vin_gt_vout` = 0, the valley flag ends the phase (next phase 3). The sum-limit flag is ignored.
- R7: Phase 1 lasts at most TIMEOUT_CYC cycles. When no limit ends it first, it is left for phase 3 after exactly TIMEOUT_CYC cycles.
- R8: In buck-only mode (`buck_only` = 1), phase 2 is never entered. Charging runs in phase 1 until the peak-limit-1 flag (the sum-limit flag is ignored) or the timeout, and then goes to phase 3.
- R9: Phase 3 holds until the valley flag or the below-zero flag is sampled high.
- R10: In discontinuous conduction (`ccm` = 0), the block stays in phase 4 after phase 3 until a charge request arrives.
- R11: In continuous conduction with `zc_cmp_dis` = 1, phase 4 lasts exactly FREEWHEEL_CYC cycles and is then followed by a charging phase, with no charge request needed.
- R12: In continuous conduction with `zc_cmp_dis` = 0, the end of phase 3 is followed directly (after dead time) by a charging phase, and phase 4 is skipped.
- R13: With `softstart` = 1, `ccm` is treated as 0 and the valley flag is ignored in phase 3. `ss_over_lim1` and `ss_over_limsum` take the place of `over_lim1` and `over_limsum`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Regulator enable; low holds all gates off |
| buck_only | input | 1 | 1 = buck-only mode, 0 = buck-boost mode |
| zc_cmp_dis | input | 1 | 1 = zero-current comparator disabled (timed freewheel in CCM) |
| softstart | input | 1 | Start-up in progress |
| ccm | input | 1 | Continuous-conduction indication from the limit loop |
| vin_gt_vout | input | 1 | Input voltage above output voltage |
| charge_req | input | 1 | Charge request from the hysteretic loop |
| over_lim1 | input | 1 | Inductor current at or above peak limit 1 |
| over_limsum | input | 1 | Inductor current at or above limit 1 plus limit 2 |
| ss_over_lim1 | input | 1 | Soft-start counterpart of `over_lim1` |
| ss_over_limsum | input | 1 | Soft-start counterpart of `over_limsum` |
| at_valley | input | 1 | Inductor current at or below the valley limit |
| below_zero | input | 1 | Inductor current below zero |
| gate_in_hi | output | 1 | Input-side high switch |
| gate_in_lo | output | 1 | Input-side low switch |
| gate_out_hi | output | 1 | Output-side high switch |
| gate_out_lo | output | 1 | Output-side low switch |
| phase | output | 3 | Phase code, 0 = idle/dead, 1..4 = phases |

## Verification
The bench times phase 1 cycle by cycle until the timeout. An off-by-one counter would leave the phase one cycle early or late. It also counts the cycles of the continuous-conduction freewheel, which an exit condition tested on the wrong count value would shorten or stretch. It feeds in flags that must be ignored: the sum limit while VIN is not above VOUT, the sum limit in buck-only mode, the valley flag and the normal limits during soft-start, and a charge request while disabled. Decoding any of them would end a phase too early or wake the stage. Every phase change is sampled in the dead cycle, so a missing break-before-make gap shows up as a direct jump between two non-zero codes.

// File: rtl/bb_phase_seq.sv
module bb_phase_seq #(
  parameter int TIMEOUT_CYC   = 50,
  parameter int FREEWHEEL_CYC = 3,
  parameter int DEAD_CYC      = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic       buck_only,
  input  logic       zc_cmp_dis,
  input  logic       softstart,
  input  logic       ccm,
  input  logic       vin_gt_vout,
  input  logic       charge_req,
  input  logic       over_lim1,
  input  logic       over_limsum,
  input  logic       ss_over_lim1,
  input  logic       ss_over_limsum,
  input  logic       at_valley,
  input  logic       below_zero,
  output logic       gate_in_hi,
  output logic       gate_in_lo,
  output logic       gate_out_hi,
  output logic       gate_out_lo,
  output logic [2:0] phase
);

  localparam int MAX_A = (TIMEOUT_CYC > FREEWHEEL_CYC) ? TIMEOUT_CYC : FREEWHEEL_CYC;
  localparam int MAX_C = (MAX_A > DEAD_CYC) ? MAX_A : DEAD_CYC;
  localparam int CW    = $clog2(MAX_C + 1);
  localparam logic [CW-1:0] TO_LAST   = CW'(TIMEOUT_CYC - 1);
  localparam logic [CW-1:0] FW_LAST   = CW'(FREEWHEEL_CYC - 1);
  localparam logic [CW-1:0] DEAD_LAST = CW'(DEAD_CYC - 1);

  typedef enum logic [2:0] {S_IDLE, S_DEAD, S_P1, S_P2, S_P3, S_P4} st_t;

  st_t           st, tgt, dest;
  logic [CW-1:0] cnt;
  logic          go;

  wire lim1     = softstart ? ss_over_lim1   : over_lim1;
  wire limsum   = softstart ? ss_over_limsum : over_limsum;
  wire ccm_eff  = ccm & ~softstart;
  wire valley   = at_valley & ~softstart;
  wire dis_done = valley | below_zero;
  wire fw_timed = ccm_eff & zc_cmp_dis;

  always_comb begin
    go   = 1'b0;
    dest = S_P2;
    case (st)
      S_IDLE: go = charge_req;
      S_P2: begin
        go   = lim1;
        dest = S_P1;
      end
      S_P1: begin
        dest = S_P3;
        if (cnt >= TO_LAST)  go = 1'b1;
        else if (buck_only)  go = lim1;
        else if (vin_gt_vout) go = limsum;
        else                 go = valley;
      end
      S_P3: begin
        go   = dis_done;
        dest = (ccm_eff && !zc_cmp_dis) ? S_P2 : S_P4;
      end
      S_P4: go = fw_timed ? (cnt >= FW_LAST) : (charge_req | ccm_eff);
      default: go = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= S_IDLE;
      tgt <= S_P2;
      cnt <= '0;
    end else if (!enable) begin
      st  <= S_IDLE;
      cnt <= '0;
    end else if (st == S_DEAD) begin
      if (cnt >= DEAD_LAST) begin
        st  <= (tgt == S_P2 && buck_only) ? S_P1 : tgt;
        cnt <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end else if (go) begin
      st  <= S_DEAD;
      tgt <= dest;
      cnt <= '0;
    end else if (cnt != '1) begin
      cnt <= cnt + 1'b1;
    end
  end

  always_comb begin
    phase = 3'd0;
    case (st)
      S_P1: phase = 3'd1;
      S_P2: phase = 3'd2;
      S_P3: phase = 3'd3;
      S_P4: phase = 3'd4;
      default: phase = 3'd0;
    endcase
  end

  assign gate_in_hi  = (st == S_P1) || (st == S_P2);
  assign gate_in_lo  = (st == S_P3) || (st == S_P4);
  assign gate_out_hi = (st == S_P1) || (st == S_P3);
  assign gate_out_lo = (st == S_P2) || (st == S_P4);

  logic [CW:0] p1_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            p1_run <= '0;
    else if (phase == 3'd1) p1_run <= p1_run + 1'b1;
    else                   p1_run <= '0;
  end

  AST_TWO_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != 3'd0) |-> ($countones({gate_in_hi, gate_in_lo, gate_out_hi, gate_out_lo}) == 2)); // R2
  AST_OFF_CODE0: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 3'd0) |-> !(gate_in_hi || gate_in_lo || gate_out_hi || gate_out_lo)); // R2
  AST_DIS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (phase == 3'd0)); // R1
  AST_DEAD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != 3'd0) |=> (phase == $past(phase) || phase == 3'd0)); // R3
  AST_NO_P2_BUCK: assert property (@(posedge clk) disable iff (!rst_n)
    (buck_only && phase != 3'd2) |=> (phase != 3'd2)); // R8
  AST_P1_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    p1_run <= (CW+1)'(TIMEOUT_CYC)); // R7
  AST_SS_VALLEY: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && softstart && phase == 3'd3 && !below_zero) |=> (phase == 3'd3)); // R13

endmodule

// File: tb/bb_phase_seq_test.sv
module bb_phase_seq_test;
  localparam int PERIOD = 10;
  localparam int TMO = 50;
  localparam int FW  = 3;

  logic clk = 1'b0;
  logic rst_n, enable, buck_only, zc_cmp_dis, softstart, ccm, vin_gt_vout, charge_req;
  logic over_lim1, over_limsum, ss_over_lim1, ss_over_limsum, at_valley, below_zero;
  logic gate_in_hi, gate_in_lo, gate_out_hi, gate_out_lo;
  logic [2:0] phase;
  int checks = 0;
  int errors = 0;

  always #(PERIOD/2) clk = ~clk;

  bb_phase_seq #(.TIMEOUT_CYC(TMO), .FREEWHEEL_CYC(FW), .DEAD_CYC(1)) uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .buck_only(buck_only),
    .zc_cmp_dis(zc_cmp_dis), .softstart(softstart), .ccm(ccm),
    .vin_gt_vout(vin_gt_vout), .charge_req(charge_req),
    .over_lim1(over_lim1), .over_limsum(over_limsum),
    .ss_over_lim1(ss_over_lim1), .ss_over_limsum(ss_over_limsum),
    .at_valley(at_valley), .below_zero(below_zero),
    .gate_in_hi(gate_in_hi), .gate_in_lo(gate_in_lo),
    .gate_out_hi(gate_out_hi), .gate_out_lo(gate_out_lo), .phase(phase));

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic expect_ph(input int exp, input string req);
    logic [3:0] eg, ag;
    case (exp)
      1: eg = 4'b1010;
      2: eg = 4'b1001;
      3: eg = 4'b0110;
      4: eg = 4'b0101;
      default: eg = 4'b0000;
    endcase
    ag = {gate_in_hi, gate_in_lo, gate_out_hi, gate_out_lo};
    checks++;
    if (int'(phase) != exp || ag != eg) begin
      errors++;
      $display("FAIL %s: phase=%0d gates=%b expected phase=%0d gates=%b", req, phase, ag, exp, eg);
    end
  endtask

  task automatic expect_n(input int act, input int exp, input string req);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: count=%0d expected %0d", req, act, exp);
    end
  endtask

  task automatic reset_all();
    rst_n = 0; enable = 0; buck_only = 0; zc_cmp_dis = 0; softstart = 0; ccm = 0;
    vin_gt_vout = 0; charge_req = 0; over_lim1 = 0; over_limsum = 0;
    ss_over_lim1 = 0; ss_over_limsum = 0; at_valley = 0; below_zero = 0;
    tick(); tick();
    rst_n = 1;
    tick();
    expect_ph(0, "R1 reset");
    enable = 1;
  endtask

  task automatic start_p2();
    charge_req = 1; tick(); expect_ph(0, "R3 dead before charge");
    tick(); expect_ph(2, "R4 charge starts in phase 2");
    charge_req = 0;
  endtask

  task automatic p2_to_p1();
    over_lim1 = 1; tick(); expect_ph(0, "R3 dead 2->1");
    over_lim1 = 0; tick(); expect_ph(1, "R4 lim1 moves to phase 1");
  endtask

  task automatic p1_to_p3_sum();
    over_limsum = 1; tick(); expect_ph(0, "R3 dead 1->3");
    over_limsum = 0; tick(); expect_ph(3, "R5 sum limit ends phase 1");
  endtask

  task automatic test_bb_high();
    reset_all();
    vin_gt_vout = 1;
    start_p2();
    over_lim1 = 1; tick(); expect_ph(0, "R3 dead 2->1");
    tick(); expect_ph(1, "R4 phase 1 after lim1");
    tick(); tick(); expect_ph(1, "R5 lim1 alone keeps phase 1");
    over_lim1 = 0;
    p1_to_p3_sum();
    tick(); expect_ph(3, "R9 phase 3 holds");
    at_valley = 1; tick(); expect_ph(0, "R3 dead 3->4");
    at_valley = 0; tick(); expect_ph(4, "R9 valley ends phase 3");
    repeat (5) tick();
    expect_ph(4, "R10 DCM freewheel waits");
    start_p2();
  endtask

  task automatic test_bb_low();
    reset_all();
    vin_gt_vout = 0;
    start_p2();
    p2_to_p1();
    over_limsum = 1; tick(); tick(); expect_ph(1, "R6 sum limit ignored when VIN<=VOUT");
    at_valley = 1; tick(); expect_ph(0, "R3 dead 1->3");
    tick(); expect_ph(3, "R6 valley ends phase 1");
    at_valley = 0; over_limsum = 0;
    below_zero = 1; tick(); expect_ph(0, "R3 dead 3->4");
    below_zero = 0; tick(); expect_ph(4, "R9 below zero ends phase 3");
  endtask

  task automatic test_timeout();
    int n;
    reset_all();
    vin_gt_vout = 1;
    start_p2();
    p2_to_p1();
    n = 1;
    for (int i = 0; i < 200; i++) begin
      tick();
      if (phase != 3'd1) break;
      n++;
    end
    expect_n(n, TMO, "R7 phase 1 length at timeout");
    expect_ph(0, "R3 dead after timeout");
    tick(); expect_ph(3, "R7 timeout goes to phase 3");
  endtask

  task automatic test_buck_only();
    reset_all();
    buck_only = 1; vin_gt_vout = 1;
    charge_req = 1; tick(); expect_ph(0, "R3 dead before buck charge");
    tick(); expect_ph(1, "R8 buck-only charges in phase 1");
    charge_req = 0;
    over_limsum = 1; tick(); tick(); expect_ph(1, "R8 sum limit ignored in buck-only");
    over_limsum = 0;
    over_lim1 = 1; tick(); expect_ph(0, "R3 dead 1->3");
    over_lim1 = 0; tick(); expect_ph(3, "R8 lim1 ends buck charge");
  endtask

  task automatic test_ccm_fw();
    int n;
    reset_all();
    vin_gt_vout = 1; ccm = 1; zc_cmp_dis = 1;
    start_p2(); p2_to_p1(); p1_to_p3_sum();
    at_valley = 1; tick(); expect_ph(0, "R3 dead 3->4");
    at_valley = 0; tick(); expect_ph(4, "R11 timed freewheel entered");
    n = 1;
    for (int i = 0; i < 50; i++) begin
      tick();
      if (phase != 3'd4) break;
      n++;
    end
    expect_n(n, FW, "R11 freewheel length");
    expect_ph(0, "R3 dead 4->2");
    tick(); expect_ph(2, "R11 charge resumes without request");
  endtask

  task automatic test_ccm_skip();
    reset_all();
    vin_gt_vout = 1; ccm = 1; zc_cmp_dis = 0;
    start_p2(); p2_to_p1(); p1_to_p3_sum();
    at_valley = 1; tick(); expect_ph(0, "R3 dead 3->2");
    at_valley = 0; tick(); expect_ph(2, "R12 phase 4 skipped");
  endtask

  task automatic test_softstart();
    reset_all();
    softstart = 1; ccm = 1; zc_cmp_dis = 0; vin_gt_vout = 1;
    start_p2();
    over_lim1 = 1; tick(); tick(); expect_ph(2, "R13 normal lim1 ignored");
    ss_over_lim1 = 1; tick(); expect_ph(0, "R3 dead 2->1");
    tick(); expect_ph(1, "R13 soft-start lim1 used");
    over_lim1 = 0; ss_over_lim1 = 0;
    over_limsum = 1; tick(); expect_ph(1, "R13 normal sum limit ignored");
    ss_over_limsum = 1; tick(); expect_ph(0, "R3 dead 1->3");
    over_limsum = 0; ss_over_limsum = 0;
    tick(); expect_ph(3, "R13 soft-start sum limit used");
    at_valley = 1; tick(); tick(); expect_ph(3, "R13 valley ignored");
    below_zero = 1; tick(); expect_ph(0, "R3 dead 3->4");
    below_zero = 0; at_valley = 0;
    tick(); expect_ph(4, "R13 forced DCM freewheel");
    tick(); tick(); expect_ph(4, "R13 ccm ignored during soft-start");
  endtask

  task automatic test_disable();
    reset_all();
    start_p2();
    enable = 0; tick(); expect_ph(0, "R1 disable turns gates off");
    charge_req = 1; tick(); tick(); expect_ph(0, "R1 request ignored while disabled");
    charge_req = 0;
  endtask

  initial begin
    #(PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    test_bb_high();
    test_bb_low();
    test_timeout();
    test_buck_only();
    test_ccm_fw();
    test_ccm_skip();
    test_softstart();
    test_disable();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule